// File: doc/BRIEF.md
# Multi-core reset and boot controller

This block controls reset and start-up for a cluster of up to four processor cores and two peripheral units. Software reaches it through a simple word-wide register bus. The registers are one control word, one status word, one mask word and a bank of scratch words. The scratch words hold, for each core, an entry address and an argument that are used when that core is started.

The control word is the only register with side effects. On each write to it, the block compares the stored value with the new one and acts only on bits that differ. A core-enable bit that changes makes the block queue a start or stop request for that core. The request carries the address and argument read from the core's scratch pair. A core-reset bit that changes makes the block send a one-cycle reset pulse to that core. In both cases a pending-clear flag is armed, and it drops the core's reset bit once the core returns an asynchronous completion acknowledge. The two peripheral reset bits clear themselves in the same write that changes them.

Top module: `cluster_boot_ctl`

## Requirements
- R1: After reset, control reads CTRL_RST (default 0x00000521), status reads 0x00000001, mask reads 0x0000001F and every scratch word reads 0.
- R2: The register index is the byte address shifted right by two. Index 0 is control, 1 is status, 2 is mask, and 3+j is scratch word j. A valid write to status, mask or scratch stores the written value unchanged, and a read returns it one cycle later on bus_rdata.
- R3: An access whose address is not a multiple of four, or whose index is at least 3+NSCR, changes no register. In the following cycle bus_err is 1 and bus_rdata is 0.
- R4: A control write that equals the stored value, or that only changes bits outside the core fields and peripheral bits, produces no reset pulse and no boot request.
- R5: When the enable bit of core k (k = 1..NCORE-1, bit EN_LSB+k-1, default 22+k-1) changes, the cycle after the write shows boot_valid=1 and boot_core=k. boot_addr is scratch word 2k and boot_arg is scratch word 2k+1, both as stored at the time of the write. boot_start equals the new enable bit (1 = start, 0 = stop). Core 0 never gets a request.
- R6: Requests from one write come out one per cycle, with the highest core number first (3, then 2, then 1). boot_valid is 0 in the cycle after the last one.
- R7: For a core whose enable bit changes, the same write produces no reset pulse for that core, even if its reset bit also changes. The reset bit is stored as written, and core_clr_req for that core goes to 1 in the cycle after the write.
- R8: When the reset bit of core k (bit RST_LSB+k, default 13+k) changes and its enable bit does not, core_rst_pulse[k] is 1 for exactly the cycle after the write. core_clr_req[k] then stays 1 until core_clr_ack[k] has been seen high through the SYNC_STAGES-flop synchronizer. It falls SYNC_STAGES+1 cycles after the acknowledge rises, and at that point the reset bit reads 0.
- R9: If a pending clear completes in the same cycle as a control write, the reset bit of that core reads 0 afterwards, whatever value the write carried for it. All other bits take the written value.
- R10: A peripheral reset bit (bit PER0_BIT or PER1_BIT, default 3 and 12) that changes in a control write is stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the 4 KiB region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Bad-access flag, registered |
| core_rst_pulse | output | NCORE | One-cycle reset pulse per core |
| core_clr_req | output | NCORE | Pending-clear flag per core |
| core_clr_ack | input | NCORE | Asynchronous completion acknowledge per core |
| boot_valid | output | 1 | Boot request valid, one cycle per request |
| boot_start | output | 1 | 1 = start core, 0 = stop core |
| boot_core | output | 2 | Core number of the request |
| boot_addr | output | 32 | Entry address |
| boot_arg | output | 32 | Context argument |

## Verification
The bench builds the block with NCORE=4, NSCR=8 and SYNC_STAGES=2, which gives an 11-word map whose first bad index is 11. It sweeps all 64 transitions of the three enable bits, so every mix of start and stop requests in one write is checked, together with the 3-2-1 issue order and the stored-time payloads. The two-flop synchronizer sets an exact acknowledge latency of three cycles. This lets the bench line up a control write with a completing clear and check that the clear wins for that bit.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
   localparam int WORD_W   = 32;
   localparam int CORE_W   = 2;
   localparam int IDX_CTRL = 0;
   localparam int IDX_STAT = 1;
   localparam int IDX_MASK = 2;
   localparam int IDX_SCR0 = 3;

   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      logic              start;
      logic [CORE_W-1:0] core;
      word_t             addr;
      word_t             arg;
   } boot_req_t;
endpackage

// File: rtl/cbc_ack_sync.sv
module cbc_ack_sync #(
   parameter int N      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_async,
   output logic [N-1:0] q_sync
);
   initial begin : g_chk
      assert (STAGES >= 0 && STAGES <= 4) else $error("cbc_ack_sync: STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_pass
         assign q_sync = d_async;
      end else begin : g_chain
         logic [N-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= '0;
            end else begin
               st[0] <= d_async;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q_sync = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cbc_bus_dec.sv
module cbc_bus_dec import cbc_pkg::*; #(
   parameter int ADDR_W = 12,
   parameter int NREG   = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  word_t             rd_words [NREG],
   output logic              wr_en,
   output logic [ADDR_W-3:0] wr_idx,
   output word_t             rdata,
   output logic              err
);
   localparam int IDX_W = ADDR_W - 2;

   initial begin : g_chk
      assert (NREG >= 1 && (ADDR_W - 2) >= $clog2(NREG + 1))
         else $error("cbc_bus_dec: region too small for register count");
   end

   logic [IDX_W-1:0] idx;
   logic             hit;
   word_t            rsel;

   assign idx    = addr[ADDR_W-1:2];
   assign hit    = (addr[1:0] == 2'b00) && (32'(idx) < 32'(NREG));
   assign wr_en  = sel && wr && hit;
   assign wr_idx = idx;

   always_comb begin
      rsel = '0;
      for (int i = 0; i < NREG; i++) begin
         if (idx == IDX_W'(i)) rsel = rd_words[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         rdata <= (sel && !wr && hit) ? rsel : '0;
         err   <= sel && !hit;
      end
   end

   p_err_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (rdata == '0));
endmodule

// File: rtl/cbc_ctrl_reg.sv
module cbc_ctrl_reg import cbc_pkg::*; #(
   parameter int    NCORE    = 4,
   parameter int    RST_LSB  = 13,
   parameter int    EN_LSB   = 22,
   parameter int    PER0_BIT = 3,
   parameter int    PER1_BIT = 12,
   parameter word_t CTRL_RST = 32'h0000_0521
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  word_t            wdata,
   input  logic [NCORE-1:0] ack_s,
   output word_t            ctrl_q,
   output logic [NCORE-1:0] rst_pulse,
   output logic [NCORE-1:0] pend,
   output logic [NCORE-1:0] en_chg,
   output logic [NCORE-1:0] en_val
);
   initial begin : g_chk
      assert (NCORE >= 2 && NCORE <= 4) else $error("cbc_ctrl_reg: NCORE must be 2..4");
      assert (RST_LSB + NCORE <= WORD_W) else $error("cbc_ctrl_reg: reset field overflows");
      assert (EN_LSB + NCORE - 1 <= WORD_W) else $error("cbc_ctrl_reg: enable field overflows");
      assert (PER0_BIT < WORD_W && PER1_BIT < WORD_W && PER0_BIT != PER1_BIT)
         else $error("cbc_ctrl_reg: bad peripheral bit");
   end

   word_t            chg;
   word_t            ctrl_d;
   logic [NCORE-1:0] rst_hit;
   logic [NCORE-1:0] clr;
   logic [NCORE-1:0] arm;

   assign chg = ctrl_q ^ wdata;

   generate
      for (genvar k = 0; k < NCORE; k++) begin : g_core
         if (k == 0) begin : g_noen
            assign en_chg[k] = 1'b0;
            assign en_val[k] = 1'b0;
         end else begin : g_en
            assign en_chg[k] = wr && chg[EN_LSB+k-1];
            assign en_val[k] = wdata[EN_LSB+k-1];
         end
         assign rst_hit[k] = wr && chg[RST_LSB+k] && !en_chg[k];
         assign clr[k]     = pend[k] && ack_s[k];
         assign arm[k]     = rst_hit[k] || en_chg[k];

         p_en_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(en_chg[k]) |-> !rst_pulse[k]);
         p_pend_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend[k]) |-> $past(ack_s[k]));
         p_clr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(pend[k] && ack_s[k]) |-> !ctrl_q[RST_LSB+k]);
         p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
            rst_pulse[k] |-> $past(wr));
      end
   endgenerate

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr) begin
         ctrl_d = wdata;
         if (chg[PER0_BIT]) ctrl_d[PER0_BIT] = 1'b0;
         if (chg[PER1_BIT]) ctrl_d[PER1_BIT] = 1'b0;
      end
      for (int k = 0; k < NCORE; k++) begin
         if (clr[k]) ctrl_d[RST_LSB+k] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= CTRL_RST;
         pend      <= '0;
         rst_pulse <= '0;
      end else begin
         ctrl_q    <= ctrl_d;
         pend      <= (pend & ~clr) | arm;
         rst_pulse <= rst_hit;
      end
   end

   p_per0_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr && chg[PER0_BIT]) |-> !ctrl_q[PER0_BIT]);
   p_per1_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr && chg[PER1_BIT]) |-> !ctrl_q[PER1_BIT]);
endmodule

// File: rtl/cbc_boot_seq.sv
module cbc_boot_seq import cbc_pkg::*; #(
   parameter int NCORE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCORE-1:0] en_chg,
   input  logic [NCORE-1:0] en_val,
   input  word_t            pair_addr [NCORE],
   input  word_t            pair_arg  [NCORE],
   output logic             valid,
   output boot_req_t        req
);
   initial begin : g_chk
      assert (NCORE >= 2 && NCORE <= (1 << CORE_W)) else $error("cbc_boot_seq: NCORE too large");
   end

   logic [NCORE-1:0]  slot_v;
   logic [NCORE-1:0]  pop;
   boot_req_t         slot [NCORE];
   logic [CORE_W-1:0] pick;

   always_comb begin
      pick = '0;
      for (int k = 0; k < NCORE; k++) begin
         if (slot_v[k]) pick = CORE_W'(k);
      end
   end

   assign valid = |slot_v;
   assign req   = slot[pick];

   always_comb begin
      for (int k = 0; k < NCORE; k++) pop[k] = valid && (pick == CORE_W'(k));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_v <= '0;
         for (int k = 0; k < NCORE; k++) slot[k] <= '0;
      end else begin
         for (int k = 0; k < NCORE; k++) begin
            if (en_chg[k]) begin
               slot_v[k]     <= 1'b1;
               slot[k].start <= en_val[k];
               slot[k].core  <= CORE_W'(k);
               slot[k].addr  <= pair_addr[k];
               slot[k].arg   <= pair_arg[k];
            end else if (pop[k]) begin
               slot_v[k] <= 1'b0;
            end
         end
      end
   end

   p_no_core0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (req.core != '0));
   p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && $past(valid) && !$past(|en_chg)) |-> (req.core < $past(req.core)));
endmodule

// File: rtl/cluster_boot_ctl.sv
module cluster_boot_ctl import cbc_pkg::*; #(
   parameter int    ADDR_W      = 12,
   parameter int    NCORE       = 4,
   parameter int    NSCR        = 10,
   parameter int    SYNC_STAGES = 2,
   parameter int    RST_LSB     = 13,
   parameter int    EN_LSB      = 22,
   parameter int    PER0_BIT    = 3,
   parameter int    PER1_BIT    = 12,
   parameter word_t CTRL_RST    = 32'h0000_0521,
   parameter word_t STAT_RST    = 32'h0000_0001,
   parameter word_t MASK_RST    = 32'h0000_001F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_err,
   output logic [NCORE-1:0]  core_rst_pulse,
   output logic [NCORE-1:0]  core_clr_req,
   input  logic [NCORE-1:0]  core_clr_ack,
   output logic              boot_valid,
   output logic              boot_start,
   output logic [1:0]        boot_core,
   output logic [31:0]       boot_addr,
   output logic [31:0]       boot_arg
);
   localparam int NREG  = IDX_SCR0 + NSCR;
   localparam int IDX_W = ADDR_W - 2;

   initial begin : g_chk
      assert (NSCR >= 2 * NCORE) else $error("cluster_boot_ctl: scratch bank too small for core pairs");
   end

   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic              ctrl_wr;
   word_t             ctrl_q;
   word_t             stat_q;
   word_t             mask_q;
   word_t             scr_q     [NSCR];
   word_t             rd_words  [NREG];
   word_t             pair_addr [NCORE];
   word_t             pair_arg  [NCORE];
   logic [NCORE-1:0]  ack_s;
   logic [NCORE-1:0]  en_chg;
   logic [NCORE-1:0]  en_val;
   boot_req_t         req;

   cbc_bus_dec #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
      .rd_words(rd_words), .wr_en(wr_en), .wr_idx(wr_idx),
      .rdata(bus_rdata), .err(bus_err)
   );

   cbc_ack_sync #(.N(NCORE), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(core_clr_ack), .q_sync(ack_s)
   );

   assign ctrl_wr = wr_en && (wr_idx == IDX_W'(IDX_CTRL));

   cbc_ctrl_reg #(
      .NCORE(NCORE), .RST_LSB(RST_LSB), .EN_LSB(EN_LSB),
      .PER0_BIT(PER0_BIT), .PER1_BIT(PER1_BIT), .CTRL_RST(CTRL_RST)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(bus_wdata), .ack_s(ack_s),
      .ctrl_q(ctrl_q), .rst_pulse(core_rst_pulse), .pend(core_clr_req),
      .en_chg(en_chg), .en_val(en_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= STAT_RST;
         mask_q <= MASK_RST;
         for (int j = 0; j < NSCR; j++) scr_q[j] <= '0;
      end else if (wr_en) begin
         if (wr_idx == IDX_W'(IDX_STAT)) stat_q <= bus_wdata;
         if (wr_idx == IDX_W'(IDX_MASK)) mask_q <= bus_wdata;
         for (int j = 0; j < NSCR; j++) begin
            if (wr_idx == IDX_W'(IDX_SCR0 + j)) scr_q[j] <= bus_wdata;
         end
      end
   end

   assign rd_words[IDX_CTRL] = ctrl_q;
   assign rd_words[IDX_STAT] = stat_q;
   assign rd_words[IDX_MASK] = mask_q;

   generate
      for (genvar j = 0; j < NSCR; j++) begin : g_rd
         assign rd_words[IDX_SCR0+j] = scr_q[j];
      end
      for (genvar k = 0; k < NCORE; k++) begin : g_pair
         assign pair_addr[k] = scr_q[2*k];
         assign pair_arg[k]  = scr_q[2*k+1];
      end
   endgenerate

   cbc_boot_seq #(.NCORE(NCORE)) u_seq (
      .clk(clk), .rst_n(rst_n), .en_chg(en_chg), .en_val(en_val),
      .pair_addr(pair_addr), .pair_arg(pair_arg), .valid(boot_valid), .req(req)
   );

   assign boot_start = req.start;
   assign boot_core  = req.core;
   assign boot_addr  = req.addr;
   assign boot_arg   = req.arg;

   p_bad_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> ($stable(stat_q) && $stable(mask_q) && $stable(scr_q[0])));
endmodule

// File: tb/cluster_boot_ctl_bench.sv
module cluster_boot_ctl_bench;
   localparam int CLK_P   = 10;
   localparam int NCORE   = 4;
   localparam int NSCR    = 8;
   localparam int SYNC    = 2;
   localparam int RST_LSB = 13;
   localparam int EN_LSB  = 22;
   localparam int PER0    = 3;
   localparam int PER1    = 12;
   localparam logic [31:0] BASE = 32'h0000_0521;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic [3:0]  core_rst_pulse;
   logic [3:0]  core_clr_req;
   logic [3:0]  core_clr_ack = '0;
   logic        boot_valid;
   logic        boot_start;
   logic [1:0]  boot_core;
   logic [31:0] boot_addr;
   logic [31:0] boot_arg;

   int total = 0;
   int bad = 0;

   always #(CLK_P/2) clk = ~clk;

   cluster_boot_ctl #(.NCORE(NCORE), .NSCR(NSCR), .SYNC_STAGES(SYNC)) u_cluster_boot_ctl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .core_rst_pulse(core_rst_pulse), .core_clr_req(core_clr_req),
      .core_clr_ack(core_clr_ack), .boot_valid(boot_valid), .boot_start(boot_start),
      .boot_core(boot_core), .boot_addr(boot_addr), .boot_arg(boot_arg)
   );

   function automatic logic [31:0] scr_val(input int j);
      return 32'h0100_0000 * (j + 1) + 32'(j * 3);
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [11:0] a, output logic [31:0] d, output logic e);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata; e = bus_err;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      logic        er;
      logic [31:0] cur;
      logic [2:0]  dif;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset values
      bread(12'h000, rd, er); chk("R1", "ctrl", {32'(er), rd}, {32'd0, BASE});
      bread(12'h004, rd, er); chk("R1", "stat", {32'(er), rd}, {32'd0, 32'h1});
      bread(12'h008, rd, er); chk("R1", "mask", {32'(er), rd}, {32'd0, 32'h1F});
      for (int j = 0; j < NSCR; j++) begin
         bread(12'(12 + 4*j), rd, er); chk("R1", "scratch", {32'(er), rd}, 64'd0);
      end

      // R2 plain storage
      bwrite(12'h004, 32'hDEAD_BEEF);
      bwrite(12'h008, 32'h1234_5678);
      bread(12'h004, rd, er); chk("R2", "stat", {32'(er), rd}, {32'd0, 32'hDEAD_BEEF});
      bread(12'h008, rd, er); chk("R2", "mask", {32'(er), rd}, {32'd0, 32'h1234_5678});
      for (int j = 0; j < NSCR; j++) bwrite(12'(12 + 4*j), scr_val(j));
      for (int j = 0; j < NSCR; j++) begin
         bread(12'(12 + 4*j), rd, er); chk("R2", "scratch", {32'(er), rd}, {32'd0, scr_val(j)});
      end

      // R3 bad accesses
      bread(12'h02C, rd, er); chk("R3", "idx11 read", {32'(er), rd}, {32'd1, 32'd0});
      bread(12'hFFC, rd, er); chk("R3", "top read", {32'(er), rd}, {32'd1, 32'd0});
      bread(12'h00D, rd, er); chk("R3", "misaligned read", {32'(er), rd}, {32'd1, 32'd0});
      bwrite(12'h00E, 32'hFFFF_FFFF); chk("R3", "misaligned write err", 64'(bus_err), 64'd1);
      bwrite(12'h02C, 32'hFFFF_FFFF); chk("R3", "range write err", 64'(bus_err), 64'd1);
      bread(12'h00C, rd, er); chk("R3", "scratch0 kept", {32'(er), rd}, {32'd0, scr_val(0)});
      bread(12'h004, rd, er); chk("R3", "stat kept", {32'(er), rd}, {32'd0, 32'hDEAD_BEEF});

      // R4 unchanged / plain bits
      bwrite(12'h000, BASE);
      chk("R4", "same value", {62'd0, boot_valid, |core_rst_pulse}, 64'd0);
      bwrite(12'h000, BASE | 32'h2);
      chk("R4", "plain bit", {62'd0, boot_valid, |core_rst_pulse}, 64'd0);
      idle(1); chk("R4", "later idle", {62'd0, boot_valid, |core_rst_pulse}, 64'd0);
      bread(12'h000, rd, er); chk("R4", "plain bit stored", 64'(rd), 64'(BASE | 32'h2));
      bwrite(12'h000, BASE); idle(2);

      // R5 R6 R7 sweep of all enable transitions
      for (int o = 0; o < 8; o++) begin
         for (int n = 0; n < 8; n++) begin
            bwrite(12'h000, BASE | (32'(o) << EN_LSB));
            idle(4);
            bwrite(12'h000, BASE | (32'(n) << EN_LSB));
            chk("R7", "no pulse on enable", 64'(core_rst_pulse), 64'd0);
            dif = 3'(o ^ n);
            for (int c = 3; c >= 1; c--) begin
               if (dif[c-1]) begin
                  chk("R6", "order", {59'd0, boot_valid, boot_start, boot_core, 1'b0},
                      {59'd0, 1'b1, 1'(n >> (c-1)), 2'(c), 1'b0});
                  chk("R5", "payload", {boot_addr, boot_arg}, {scr_val(2*c), scr_val(2*c+1)});
                  @(negedge clk);
               end
            end
            chk("R6", "idle after burst", 64'(boot_valid), 64'd0);
         end
      end
      bwrite(12'h000, BASE); idle(4);
      core_clr_ack = 4'hF; idle(6); core_clr_ack = 4'h0; idle(4);
      chk("R8", "all clears done", 64'(core_clr_req), 64'd0);

      // R7 enable and reset bit changed together
      cur = BASE | (32'h1 << EN_LSB) | (32'h1 << (RST_LSB + 1));
      bwrite(12'h000, cur);
      chk("R7", "no pulse core1", 64'(core_rst_pulse), 64'd0);
      chk("R7", "clear armed", 64'(core_clr_req), 64'h2);
      chk("R5", "start core1", {61'd0, boot_valid, boot_start, boot_core == 2'd1}, 64'h7);
      idle(1);
      bread(12'h000, rd, er); chk("R7", "reset bit stored", 64'(rd), 64'(cur));
      core_clr_ack = 4'h2; idle(5); core_clr_ack = 4'h0;
      cur = BASE | (32'h1 << EN_LSB);
      bread(12'h000, rd, er); chk("R8", "bit cleared after ack", 64'(rd), 64'(cur));
      chk("R8", "clear req dropped", 64'(core_clr_req), 64'd0);
      idle(3);

      // R8 per-core reset pulses and acknowledge latency
      for (int k = 0; k < NCORE; k++) begin
         bwrite(12'h000, cur | (32'h1 << (RST_LSB + k)));
         chk("R8", "pulse", 64'(core_rst_pulse), 64'(4'h1 << k));
         chk("R8", "clr req", 64'(core_clr_req), 64'(4'h1 << k));
         @(negedge clk);
         chk("R8", "pulse one cycle", 64'(core_rst_pulse), 64'd0);
         idle(2);
         bread(12'h000, rd, er); chk("R8", "bit held", 64'(rd[RST_LSB+k]), 64'd1);
         core_clr_ack = 4'h1 << k;
         idle(SYNC);
         chk("R8", "req before latency", 64'(core_clr_req[k]), 64'd1);
         idle(1);
         chk("R8", "req at latency", 64'(core_clr_req[k]), 64'd0);
         core_clr_ack = 4'h0;
         bread(12'h000, rd, er); chk("R8", "bit cleared", 64'(rd), 64'(cur));
         idle(3);
      end
      bwrite(12'h000, cur | (32'h5 << RST_LSB));
      chk("R8", "two pulses", 64'(core_rst_pulse), 64'h5);
      core_clr_ack = 4'h5; idle(6); core_clr_ack = 4'h0; idle(3);
      bread(12'h000, rd, er); chk("R8", "both cleared", 64'(rd), 64'(cur));

      // R9 clear collides with a write
      core_clr_ack = 4'h4; idle(4);
      bwrite(12'h000, cur | (32'h1 << (RST_LSB + 2)));
      chk("R9", "pulse core2", 64'(core_rst_pulse), 64'h4);
      bwrite(12'h000, cur | (32'h1 << (RST_LSB + 2)) | 32'h2);
      core_clr_ack = 4'h0;
      bread(12'h000, rd, er); chk("R9", "clear wins", 64'(rd), 64'(cur | 32'h2));
      chk("R9", "no pending", 64'(core_clr_req), 64'd0);
      cur = cur | 32'h2;
      idle(3);

      // R10 peripheral bits
      bwrite(12'h000, cur | (32'h1 << PER0) | (32'h1 << PER1));
      bread(12'h000, rd, er); chk("R10", "both cleared", 64'(rd), 64'(cur));
      bwrite(12'h000, cur | (32'h1 << PER1));
      bread(12'h000, rd, er); chk("R10", "one cleared", 64'(rd), 64'(cur));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule